// File: doc/BRIEF.md
# Configurable Three-Pin Status Port

This block drives three general-purpose status pins. Each pin picks its own source through a two-bit mode field. The sources fall into three families. The first is protocol state: voting, sync and activity. The second is timebase events from a time counter inside the block. The third is guardian gate state. So a board can show protocol health, copy the controller's timebase to other logic, or watch the bus-guardian transmit gates, all on the same three pads.

Every pin drives in one of two ways. A push-pull pin always drives its level. An open-drain pin only pulls low. While the controller is off (`port_en_i` low), every pin is released and the timebase is held at zero. Once `port_en_i` rises, the configuration takes effect and the timebase starts counting.

The timebase divides the main clock by `prescale_i + 1`. Each division step advances a 16-bit time counter. The block sends out a one-cycle tick on each step and a one-cycle wrap pulse when the counter rolls over. It also sends out a microtick square wave that changes level on every enabled clock.

Top module: `status_port`

## Requirements
- R1: While `port_en_i` is 0, and after reset, `pin_oe_o` and `pin_o` are all 0. Stimulus on the other inputs has no effect on them.
- R2: Mode code 0 selects protocol status. Pin 2 shows `vote_i`, pin 1 shows `sync_ok_i` and pin 0 shows `activity_i`.
- R3: When `swap_i` is 1, pins 2 and 0 exchange their protocol sources: pin 2 shows `activity_i` and pin 0 shows `vote_i`. `swap_i` has no effect in the other modes.
- R4: Mode code 1 on pin 0 shows the microtick. It is 1 after the first clock edge with `port_en_i` high, and it inverts on every later enabled edge.
- R5: The time counter advances once every `prescale_i + 1` enabled clocks, counted from enable. With mode code 1, pin 1 is high for exactly the one cycle after each advance.
- R6: With mode code 1, pin 2 is high for exactly one cycle: the cycle after the counter wraps from 0xFFFF to 0. With prescale 0, that is after the 65536th enabled edge.
- R7: Mode code 2 selects the guardian view. Pin 2 shows `action_time_i`, pin 1 shows `gate_open_i[1]` and pin 0 shows `gate_open_i[0]`, where 1 means the gate is open.
- R8: Mode code 3 selects a constant 0 source.
- R9: An enabled push-pull pin (`od_cfg_i[k]` = 0) has `pin_oe_o[k]` = 1 and `pin_o[k]` equal to its selected source.
- R10: An enabled open-drain pin (`od_cfg_i[k]` = 1) has `pin_o[k]` = 0, and `pin_oe_o[k]` is 1 only when the source is 0.
- R11: Each pin's mode is taken from `mode_cfg_i[2k+1:2k]`, with no effect on the other pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Main clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| port_en_i | input | 1 | Controller on and configuration applied |
| mode_cfg_i | input | 6 | Two-bit mode per pin, pin k at [2k+1:2k] |
| od_cfg_i | input | 3 | Per-pin open-drain select |
| swap_i | input | 1 | Exchange the voting and activity sources |
| prescale_i | input | 8 | Time counter divider minus one |
| vote_i | input | 1 | Agreed remote voting signal |
| sync_ok_i | input | 1 | Synchronisation valid |
| activity_i | input | 1 | Protocol activity indication |
| action_time_i | input | 1 | Start of a bus access cycle |
| gate_open_i | input | 2 | Transmit gate enables of channels 1 and 0 |
| pin_o | output | 3 | Pin data |
| pin_oe_o | output | 3 | Pin output enable |

## Verification
The assertions take three things about the inputs as given. `port_en_i` stays high through every timebase window under test. `prescale_i` does not change while the counter runs, so the tick spacing is known. The configuration inputs change only between clock edges. The stimulus drives all inputs on the falling edge. It reprograms the prescaler or mode fields only while the port is disabled, or while the outputs under check depend only on combinational sources. Each timebase scenario begins with a fresh enable, so the counter phase is known.

// File: rtl/status_port_pkg.sv
package status_port_pkg;
  localparam int N_PINS = 3;

  typedef enum logic [1:0] {
    MODE_PROTO  = 2'd0,
    MODE_TIMING = 2'd1,
    MODE_GUARD  = 2'd2,
    MODE_ZERO   = 2'd3
  } pin_mode_e;
endpackage

// File: rtl/status_timebase.sv
module status_timebase #(
  parameter int CNT_W = 16,
  parameter int PRE_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [PRE_W-1:0] prescale_i,
  output logic             tick_o,
  output logic             wrap_o,
  output logic             utick_o,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [PRE_W-1:0] pre_q;
  logic             step;

  assign step = (pre_q == prescale_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q   <= '0;
      count_o <= '0;
      tick_o  <= 1'b0;
      wrap_o  <= 1'b0;
      utick_o <= 1'b0;
    end else if (!run_i) begin
      pre_q   <= '0;
      count_o <= '0;
      tick_o  <= 1'b0;
      wrap_o  <= 1'b0;
      utick_o <= 1'b0;
    end else begin
      utick_o <= ~utick_o;
      tick_o  <= step;
      wrap_o  <= step && (count_o == CNT_MAX);
      if (step) begin
        pre_q   <= '0;
        count_o <= count_o + 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/status_pin_sel.sv
module status_pin_sel
  import status_port_pkg::*;
(
  input  pin_mode_e mode_i,
  input  logic      proto_i,
  input  logic      timing_i,
  input  logic      guard_i,
  output logic      sel_o
);
  always_comb begin
    unique case (mode_i)
      MODE_PROTO:  sel_o = proto_i;
      MODE_TIMING: sel_o = timing_i;
      MODE_GUARD:  sel_o = guard_i;
      default:     sel_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/status_pin_drive.sv
module status_pin_drive (
  input  logic en_i,
  input  logic od_i,
  input  logic sel_i,
  output logic pin_o,
  output logic oe_o
);
  always_comb begin
    if (!en_i) begin
      pin_o = 1'b0;
      oe_o  = 1'b0;
    end else if (od_i) begin
      pin_o = 1'b0;
      oe_o  = ~sel_i;
    end else begin
      pin_o = sel_i;
      oe_o  = 1'b1;
    end
  end
endmodule

// File: rtl/status_port.sv
module status_port
  import status_port_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PRE_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                port_en_i,
  input  logic [2*N_PINS-1:0] mode_cfg_i,
  input  logic [N_PINS-1:0]   od_cfg_i,
  input  logic                swap_i,
  input  logic [PRE_W-1:0]    prescale_i,
  input  logic                vote_i,
  input  logic                sync_ok_i,
  input  logic                activity_i,
  input  logic                action_time_i,
  input  logic [1:0]          gate_open_i,
  output logic [N_PINS-1:0]   pin_o,
  output logic [N_PINS-1:0]   pin_oe_o
);
  logic             tb_tick, tb_wrap, tb_utick;
  logic [CNT_W-1:0] tb_count;

  status_timebase #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_timebase (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (port_en_i),
    .prescale_i (prescale_i),
    .tick_o     (tb_tick),
    .wrap_o     (tb_wrap),
    .utick_o    (tb_utick),
    .count_o    (tb_count)
  );

  logic [N_PINS-1:0] proto_src, timing_src, guard_src, sel;

  // pin-index order: {pin2, pin1, pin0}
  assign proto_src  = swap_i ? {activity_i, sync_ok_i, vote_i}
                             : {vote_i, sync_ok_i, activity_i};
  assign timing_src = {tb_wrap, tb_tick, tb_utick};
  assign guard_src  = {action_time_i, gate_open_i};

  for (genvar k = 0; k < N_PINS; k++) begin : g_pin
    status_pin_sel u_sel (
      .mode_i   (pin_mode_e'(mode_cfg_i[2*k +: 2])),
      .proto_i  (proto_src[k]),
      .timing_i (timing_src[k]),
      .guard_i  (guard_src[k]),
      .sel_o    (sel[k])
    );
    status_pin_drive u_drive (
      .en_i  (port_en_i),
      .od_i  (od_cfg_i[k]),
      .sel_i (sel[k]),
      .pin_o (pin_o[k]),
      .oe_o  (pin_oe_o[k])
    );
  end
endmodule

// File: rtl/status_port_chk.sv
module status_port_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             port_en_i,
  input logic [2:0]       od_cfg_i,
  input logic [2:0]       pin_o,
  input logic [2:0]       pin_oe_o,
  input logic             tb_tick,
  input logic             tb_wrap,
  input logic             tb_utick,
  input logic [CNT_W-1:0] tb_count
);
  AST_OFF_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !port_en_i |-> (pin_oe_o == 3'b000 && pin_o == 3'b000)); // R1

  AST_OD_NEVER_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_o & od_cfg_i) == 3'b000); // R10

  AST_TICK_ADVANCES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_en_i |=> (tb_tick == (tb_count != $past(tb_count)))); // R5

  AST_WRAP_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tb_wrap |-> (tb_tick && tb_count == '0)); // R6

  AST_UTICK_TOGGLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_en_i |=> (tb_utick != $past(tb_utick))); // R4
endmodule

bind status_port status_port_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .port_en_i (port_en_i),
  .od_cfg_i  (od_cfg_i),
  .pin_o     (pin_o),
  .pin_oe_o  (pin_oe_o),
  .tb_tick   (tb_tick),
  .tb_wrap   (tb_wrap),
  .tb_utick  (tb_utick),
  .tb_count  (tb_count)
);

// File: tb/tb_status_port.sv
module tb_status_port;
  localparam time CLK_PERIOD = 10ns;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       port_en_i = 1'b0;
  logic [5:0] mode_cfg_i = '0;
  logic [2:0] od_cfg_i = '0;
  logic       swap_i = 1'b0;
  logic [7:0] prescale_i = '0;
  logic       vote_i = 1'b0, sync_ok_i = 1'b0, activity_i = 1'b0;
  logic       action_time_i = 1'b0;
  logic [1:0] gate_open_i = '0;
  logic [2:0] pin_o, pin_oe_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  status_port dut (.*);

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", req, got, exp);
    end
  endtask

  function automatic logic [5:0] modes(logic [1:0] m2, logic [1:0] m1, logic [1:0] m0);
    return {m2, m1, m0};
  endfunction

  task automatic settle();
    #1;
  endtask

  task automatic restart();
    @(negedge clk_i);
    port_en_i = 1'b0;
    @(negedge clk_i);
    port_en_i = 1'b1;
  endtask

  task automatic t_reset();
    settle();
    check("R1 reset oe", pin_oe_o, 3'b000);
    check("R1 reset data", pin_o, 3'b000);
    @(negedge clk_i);
    rst_ni = 1'b1;
    vote_i = 1; sync_ok_i = 1; activity_i = 1; gate_open_i = 2'b11; action_time_i = 1;
    mode_cfg_i = modes(2'd2, 2'd2, 2'd2);
    repeat (3) @(negedge clk_i);
    check("R1 disabled oe ignores inputs", pin_oe_o, 3'b000);
    check("R1 disabled data ignores inputs", pin_o, 3'b000);
  endtask

  task automatic t_protocol();
    @(negedge clk_i);
    port_en_i = 1; od_cfg_i = 0; swap_i = 0;
    mode_cfg_i = modes(2'd0, 2'd0, 2'd0);
    vote_i = 1; sync_ok_i = 0; activity_i = 0; settle();
    check("R2 vote on pin2", pin_o, 3'b100);
    check("R9 push-pull oe", pin_oe_o, 3'b111);
    vote_i = 0; sync_ok_i = 1; settle();
    check("R2 sync on pin1", pin_o, 3'b010);
    sync_ok_i = 0; activity_i = 1; settle();
    check("R2 activity on pin0", pin_o, 3'b001);
  endtask

  task automatic t_swap();
    swap_i = 1; vote_i = 1; activity_i = 0; sync_ok_i = 0; settle();
    check("R3 swapped vote on pin0", pin_o, 3'b001);
    vote_i = 0; activity_i = 1; settle();
    check("R3 swapped activity on pin2", pin_o, 3'b100);
    mode_cfg_i = modes(2'd2, 2'd2, 2'd2);
    action_time_i = 1; gate_open_i = 2'b00; settle();
    check("R3 swap ignored in guard mode", pin_o, 3'b100);
    swap_i = 0;
  endtask

  task automatic t_guard();
    mode_cfg_i = modes(2'd2, 2'd2, 2'd2);
    action_time_i = 0; gate_open_i = 2'b10; settle();
    check("R7 gate1 on pin1", pin_o, 3'b010);
    gate_open_i = 2'b01; settle();
    check("R7 gate0 on pin0", pin_o, 3'b001);
    action_time_i = 1; gate_open_i = 2'b00; settle();
    check("R7 action time on pin2", pin_o, 3'b100);
  endtask

  task automatic t_zero_mode();
    mode_cfg_i = modes(2'd3, 2'd3, 2'd3);
    vote_i = 1; sync_ok_i = 1; activity_i = 1; settle();
    check("R8 constant zero data", pin_o, 3'b000);
    od_cfg_i = 3'b111; settle();
    check("R8 zero source pulls low open-drain", pin_oe_o, 3'b111);
    od_cfg_i = 0;
  endtask

  task automatic t_open_drain();
    mode_cfg_i = modes(2'd2, 2'd2, 2'd2);
    od_cfg_i = 3'b101; action_time_i = 1; gate_open_i = 2'b10; settle();
    // pin2 od src1 -> released, pin1 pp src1, pin0 od src0 -> pulled low
    check("R10 open-drain data", pin_o, 3'b010);
    check("R10 open-drain oe", pin_oe_o, 3'b011);
    od_cfg_i = 0;
  endtask

  task automatic t_independent();
    mode_cfg_i = modes(2'd0, 2'd2, 2'd3);
    vote_i = 1; sync_ok_i = 0; activity_i = 1; gate_open_i = 2'b10; settle();
    check("R11 mixed modes", pin_o, 3'b110);
  endtask

  task automatic t_timebase();
    logic [2:0] got;
    mode_cfg_i = modes(2'd1, 2'd1, 2'd1); od_cfg_i = 0;
    prescale_i = 8'd3;
    restart();
    for (int n = 1; n <= 12; n++) begin
      @(negedge clk_i);
      got = pin_o;
      check("R5 tick on pin1", got[1], (n % 4) == 0);
      check("R4 microtick on pin0", got[0], n % 2);
      check("R6 no wrap early", got[2], 1'b0);
    end
  endtask

  task automatic t_wrap();
    mode_cfg_i = modes(2'd1, 2'd1, 2'd1);
    prescale_i = 8'd0;
    restart();
    repeat (65535) @(negedge clk_i);
    check("R6 no wrap before rollover", pin_o[2], 1'b0);
    check("R5 tick every cycle at prescale 0", pin_o[1], 1'b1);
    @(negedge clk_i);
    check("R6 wrap pulse", pin_o[2], 1'b1);
    @(negedge clk_i);
    check("R6 wrap lasts one cycle", pin_o[2], 1'b0);
  endtask

  initial begin
    t_reset();
    t_protocol();
    t_swap();
    t_guard();
    t_zero_mode();
    t_open_drain();
    t_independent();
    t_timebase();
    t_wrap();
    @(negedge clk_i);
    port_en_i = 0; settle();
    check("R1 released after disable", pin_oe_o, 3'b000);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule